// File: doc/BRIEF.md
# Programmable Line Delay Buffer

This block delays a 10-bit sample stream by a programmable number of clock cycles. The delay can be set anywhere from 2 to 2049 cycles. A circular memory of 2048 words sits between an input register and an output register. A length register sets the point at which the memory pointer wraps, so the loaded length adds exactly that many cycles to the two fixed register stages. Typical uses are aligning a video line, rate conversion and time compression or expansion.

A mode input selects plain delay or recirculation. In recirculation the output register is fed back in place of the data input, so the stored line repeats with a fixed period. A clock enable freezes every register and the pointer. An output enable forces the data output to zero without touching the internal state. A parameter selects whether the rising or the falling clock edge is the active edge.

Top module: `line_delay_buffer`

## Requirements
- R1: While reset is asserted, and after it is released, the length register, pointer and both pipeline registers are zero, so `dout_o` reads 0.
- R2: In delay mode (`mode_i`=0) with loaded length L, the output in each enabled cycle equals the input captured L+2 enabled cycles earlier. L=0 gives a latency of 2.
- R3: The largest length, 2047, gives a latency of 2049 cycles.
- R4: `len_i` is captured into the length register at an active edge where `len_load_ni` is 0 and `clk_en_i` is 1. With `clk_en_i` at 0 the strobe has no effect, and the previous latency stays in force.
- R5: In recirculation mode (`mode_i`=1) the memory input comes from the output register and `din_i` is ignored. Once the loop has filled, the output repeats with period L+2.
- R6: While `clk_en_i` is 0, `dout_o` holds its value and no sample is consumed. Delay counting resumes unchanged when the enable returns.
- R7: While `oe_i` is 0, `dout_o` is 0. The pipeline keeps running, so once `oe_i` returns the samples captured during that window come out at their normal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge is set by parameter FALL_EDGE |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; 0 freezes all state |
| mode_i | input | 1 | 0 = delay, 1 = recirculate |
| len_load_ni | input | 1 | Length load strobe, active low |
| len_i | input | 11 | Memory delay length (total delay minus 2) |
| oe_i | input | 1 | Output enable; 0 forces dout_o to zero |
| din_i | input | 10 | Sample input |
| dout_o | output | 10 | Delayed sample output |

## Verification
A length load and a stall can fall in the same cycle. The bench provokes this by holding `len_load_ni` low with a new length during a four-cycle window in which `clk_en_i` is 0. The judgement has two parts. The output must stay frozen during the window. The latency measured after the enable returns must still match the old length, which shows that the stall won over the load. The output enable is also dropped while samples are in flight, and the bench judges that those samples emerge on schedule.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  typedef enum logic {
    MODE_DELAY  = 1'b0,
    MODE_RECIRC = 1'b1
  } ldb_mode_e;
endpackage

// File: rtl/ldb_ptr.sv
module ldb_ptr #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] ptr_o
);
  logic wrap;

  // len 0 bypasses memory; a shrink past the pointer snaps it back to 0
  assign wrap = (len_i == '0) || (ptr_o >= len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (en_i) ptr_o <= wrap ? '0 : ptr_o + LEN_W'(1);
  end

  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && len_i != '0) |=> ptr_o < $past(len_i));

  p_ptr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_o));
endmodule

// File: rtl/ldb_mem.sv
module ldb_mem #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read old word, overwrite it at the edge
  assign rdata_o = mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/line_delay_buffer.sv
module line_delay_buffer #(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned LEN_W     = 11,
  parameter bit          FALL_EDGE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              mode_i,
  input  logic              len_load_ni,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  import ldb_pkg::*;

  logic              clk_int;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  ptr;
  logic [DATA_W-1:0] in_q, out_q, in_d, rd_data, mid;

  if (FALL_EDGE) begin : g_fall
    assign clk_int = ~clk_i;
  end else begin : g_rise
    assign clk_int = clk_i;
  end

  always_ff @(posedge clk_int or negedge rst_ni) begin
    if (!rst_ni)                       len_q <= '0;
    else if (clk_en_i && !len_load_ni) len_q <= len_i;
  end

  assign in_d = (mode_i == MODE_RECIRC) ? out_q : din_i;

  always_ff @(posedge clk_int or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (clk_en_i) begin
      in_q  <= in_d;
      out_q <= mid;
    end
  end

  ldb_ptr #(.LEN_W(LEN_W)) u_ptr (
    .clk_i  (clk_int),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .len_i  (len_q),
    .ptr_o  (ptr)
  );

  ldb_mem #(.DATA_W(DATA_W), .ADDR_W(LEN_W)) u_mem (
    .clk_i   (clk_int),
    .we_i    (clk_en_i),
    .addr_i  (ptr),
    .wdata_i (in_q),
    .rdata_o (rd_data)
  );

  assign mid    = (len_q == '0) ? in_q : rd_data;
  assign dout_o = oe_i ? out_q : '0;

  p_len_load_r4: assert property (@(posedge clk_int) disable iff (!rst_ni)
    (clk_en_i && !len_load_ni) |=> len_q == $past(len_i));

  p_len_hold_r4: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !clk_en_i |=> $stable(len_q));

  p_out_hold_r6: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(out_q) && $stable(in_q)));

  p_recirc_loop_r5: assert property (@(posedge clk_int) disable iff (!rst_ni)
    (clk_en_i && mode_i == MODE_RECIRC) |=> in_q == $past(out_q));

  p_min_latency_r2: assert property (@(posedge clk_int) disable iff (!rst_ni)
    (clk_en_i && len_q == '0) |=> out_q == $past(in_q));
endmodule

// File: tb/tb_line_delay_buffer.sv
module tb_line_delay_buffer;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        clk_en;
  logic        mode;
  logic        len_load_n;
  logic [10:0] len;
  logic        oe;
  logic [9:0]  din;
  logic [9:0]  dout;

  int checks = 0;
  int errors = 0;
  int m = 0;
  int cur_len = 0;
  int load_m = 0;
  logic [9:0] hist [4096];
  logic [9:0] outs [4096];

  localparam int NV = 7;
  localparam int LEN_TAB [NV] = '{0, 1, 2, 5, 17, 300, 2047};

  always #2 clk = ~clk;

  line_delay_buffer dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en), .mode_i(mode),
    .len_load_ni(len_load_n), .len_i(len), .oe_i(oe), .din_i(din), .dout_o(dout)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, m);
    end
  endtask

  // drive at negedge, let one edge pass, return at next negedge
  task automatic step(input logic [9:0] d, input logic en, input logic ld_n,
                      input logic [10:0] lv, input logic md, input logic o);
    din = d; clk_en = en; len_load_n = ld_n; len = lv; mode = md; oe = o;
    @(negedge clk);
    if (en) begin
      m++;
      hist[m & 4095] = d;
      if (!ld_n) begin
        cur_len = int'(lv);
        load_m  = m;
      end
    end
  endtask

  task automatic load_len(input int lv);
    step(10'h155, 1'b1, 1'b0, 11'(lv), 1'b0, 1'b1);
  endtask

  task automatic run_delay(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(10'((m * 7 + 3) & 10'h3FF), 1'b1, 1'b1, 11'd0, 1'b0, 1'b1);
      if (m - load_m >= 2 * cur_len + 4)
        chk(req, dout, hist[(m - cur_len - 1) & 4095]);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; clk_en = 1'b1; mode = 1'b0; len_load_n = 1'b1;
    len = '0; oe = 1'b1; din = 10'h3A5;
    repeat (3) @(negedge clk);
    chk("R1 in reset", dout, 10'h000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", dout, 10'h000);
    m = 0; load_m = 0; cur_len = 0;
    run_delay(12, "R2 default len 0");

    // table walk: one entry per loaded length
    for (int v = 0; v < NV; v++) begin
      load_len(LEN_TAB[v]);
      run_delay(2 * LEN_TAB[v] + 24, LEN_TAB[v] == 2047 ? "R3 max length" : "R2 table length");
    end

    // stall colliding with a length load: stall wins
    load_len(5);
    run_delay(30, "R2 len 5");
    for (int i = 0; i < 4; i++) begin
      automatic logic [9:0] prev = dout;
      step(10'(i * 91 + 17), 1'b0, 1'b0, 11'd9, 1'b0, 1'b1);
      chk("R6 hold while stalled", dout, prev);
    end
    run_delay(20, "R4 load blocked by stall");

    // output enable low while samples are in flight
    for (int i = 0; i < 5; i++) begin
      step(10'(i * 33 + 200), 1'b1, 1'b1, 11'd0, 1'b0, 1'b0);
      chk("R7 oe low forces zero", dout, 10'h000);
    end
    run_delay(12, "R7 pipeline undisturbed");

    // recirculation
    load_len(12);
    run_delay(40, "R2 len 12");
    begin
      automatic int s = m + 1;
      outs[m & 4095] = dout;
      for (int i = 0; i < 80; i++) begin
        step(10'((i * 13 + 5) & 10'h3FF), 1'b1, 1'b1, 11'd0, 1'b1, 1'b1);
        outs[m & 4095] = dout;
        if (m >= s + cur_len + 1)
          chk("R5 recirculation period", dout, outs[(m - cur_len - 2) & 4095]);
      end
    end

    // reset mid-run clears length back to zero
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", dout, 10'h000);
    rst_ni = 1'b1;
    load_m = m; cur_len = 0;
    run_delay(10, "R1 length zero after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule